// File: doc/BRIEF.md
# Strobed Parallel Port with Interrupt

This block is an eight-bit general-purpose port. Each pin is an input or an output, chosen one bit at a time. A host reaches the port through single-cycle register commands. A write to the data register drives new values onto the output pins. One cycle later the output strobe pulses for a programmed number of system clock cycles, so an external device can capture the data after it has settled.

An input strobe comes from outside the clock domain. It passes through a two-stage synchroniser and then raises a sticky interrupt flag. The flag can follow a rising transition of the strobe or the strobe being high, as the control register selects. The flag sets only while interrupts are enabled. The host clears it by writing a one to the status register. The status register also records any command that addressed a location that does not exist.

Top module: `strobed_pport`

## Requirements
- R1: After a synchronous active-low reset, pin_out, pin_oe, irq, stb_out and rsp_valid are all 0, every pin is an input, and all register fields are 0.
- R2: Address 1 is the direction register. Bit i = 1 makes pin i an output, and pin_oe equals this register from the cycle after the write.
- R3: A write to address 0 (data) updates pin_out from the cycle after the write. pin_out does not change without such a write.
- R4: A read of address 0 returns pin_out for bits whose direction is output and the pin_in value sampled at the read for bits whose direction is input.
- R5: A write to data raises stb_out two cycles after the command cycle. stb_out then stays high for 4, 8, 20 or 40 cycles when the width code in control bits [1:0] is 0, 1, 2 or 3.
- R6: A data write while a strobe is active restarts the full pulse width, counted from the later write.
- R7: In transition mode (control bit 2 = 0), a rising edge on stb_in sets the interrupt flag on the third clock edge after stb_in is first sampled high. A strobe that stays high does not set the flag again after it is cleared.
- R8: In level mode (control bit 2 = 1), the flag is set while the synchronised stb_in is high. A clear while stb_in is still high leaves the flag set.
- R9: The flag sets only while the enable bit (control bit 3) is 1. An event that arrives while the bit is 0 is dropped. The irq output equals the flag.
- R10: Address 3 is status: bit 0 is the interrupt flag and bit 1 is the invalid-command flag. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R11: A command to addresses 4 to 7 sets status bit 1 and changes no register, and a read of such an address returns 0.
- R12: A read command gives rsp_valid = 1 with rsp_rdata in the next cycle. Control reads back its low four bits, and the upper four bits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (40 MHz by default) |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Host command present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Register address |
| cmd_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Latched output values |
| pin_oe | output | 8 | Per-pin output enable |
| stb_in | input | 1 | Asynchronous input strobe |
| stb_out | output | 1 | Output strobe pulse |
| irq | output | 1 | Interrupt request to the host |

## Verification
The bench measures the strobe width for every width code. A counter with an off-by-one error would show up as a pulse one cycle short or long. It writes data twice in a row to catch a pulse that ignores the second write or ends early. It holds stb_in high across a clear in both detection modes. A design that detected levels in transition mode would re-raise irq, and one that let the clear win in level mode would drop it. It sends strobes while the enable bit is 0 and then sets the bit, so a design that stored the event would fire late. It also writes to unmapped addresses, which would otherwise corrupt the direction register or go unreported.

// File: rtl/pport_pkg.sv
// Shared definitions for the strobed parallel port.
// Assumes a 3-bit host address space with four mapped registers.
package pport_pkg;
    localparam int unsigned PP_ADDR_W = 3;

    typedef enum logic [PP_ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_CTRL = 3'd2,
        REG_STAT = 3'd3
    } pp_reg_e;

    // Control register layout: bit3 enable, bit2 level mode, bits1:0 width code
    typedef struct packed {
        logic       irq_en;
        logic       lvl_mode;
        logic [1:0] width_sel;
    } pp_ctrl_t;
endpackage

// File: rtl/pport_ostrobe.sv
// Output strobe generator: a load request arms the pulse, which starts one
// cycle later and lasts a width picked from four lengths given in ns.
// Assumes CLK_MHZ * width_ns is a multiple of 1000.
module pport_ostrobe #(
    parameter int CLK_MHZ = 40,
    parameter int PW0_NS  = 100,
    parameter int PW1_NS  = 200,
    parameter int PW2_NS  = 500,
    parameter int PW3_NS  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] sel_i,
    output logic       stb_o
);
    localparam int C0    = PW0_NS * CLK_MHZ / 1000;
    localparam int C1    = PW1_NS * CLK_MHZ / 1000;
    localparam int C2    = PW2_NS * CLK_MHZ / 1000;
    localparam int C3    = PW3_NS * CLK_MHZ / 1000;
    localparam int CM01  = (C0 > C1) ? C0 : C1;
    localparam int CM23  = (C2 > C3) ? C2 : C3;
    localparam int CMAX  = (CM01 > CM23) ? CM01 : CM23;
    localparam int CNT_W = $clog2(CMAX + 1);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] width;

    // Translate the width code into a cycle count
    always_comb begin
        case (sel_i)
            2'd0:    width = CNT_W'(C0);
            2'd1:    width = CNT_W'(C1);
            2'd2:    width = CNT_W'(C2);
            default: width = CNT_W'(C3);
        endcase
    end

    // Arm on load, reload the counter a cycle later, then count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            pend_q <= load_i;
            if (pend_q)
                cnt_q <= width;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign stb_o = (cnt_q != '0);

    // R6: an active pulse does not end while a reload is pending
    p_restart_keeps_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o && pend_q) |=> stb_o);
endmodule

// File: rtl/pport_istrobe.sv
// Input strobe detector: synchronises the strobe, detects a rising edge or
// a high level, and keeps a sticky interrupt flag with write-one clear.
// Assumes stb_in is asynchronous; a simultaneous set wins over a clear.
module pport_istrobe #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_i,
    input  logic lvl_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);
    logic [SYNC_STAGES:0] sh_q;
    logic                 synced;
    logic                 prev;
    logic                 event_hit;
    logic                 flag_q;

    // Synchroniser chain plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], stb_i};
    end

    assign synced = sh_q[SYNC_STAGES-1];
    assign prev   = sh_q[SYNC_STAGES];

    // Select transition or level sensitivity
    always_comb begin
        if (lvl_i) event_hit = synced;
        else       event_hit = synced & ~prev;
    end

    // Sticky flag: set by an enabled event, cleared by the host
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_q <= 1'b0;
        else if (event_hit && en_i) flag_q <= 1'b1;
        else if (clr_i)             flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R10: the flag is kept until the host clears it
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    // R9: the flag only rises while interrupts are enabled
    p_flag_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(en_i));
endmodule

// File: rtl/pport_regs.sv
// Host register file: decodes commands, holds data, direction and control,
// keeps the invalid-command flag and returns read data one cycle later.
// Assumes one command per cycle with no back-pressure.
module pport_regs
    import pport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [PP_ADDR_W-1:0] cmd_addr,
    input  logic [DW-1:0]        cmd_wdata,
    input  logic [DW-1:0]        pin_in,
    input  logic                 flag_i,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    output logic [DW-1:0]        out_o,
    output logic [DW-1:0]        dir_o,
    output pp_ctrl_t             ctrl_o,
    output logic                 load_o,
    output logic                 clr_o
);
    localparam int CTRL_W = $bits(pp_ctrl_t);

    logic [DW-1:0] out_q, dir_q, rdat;
    pp_ctrl_t      ctrl_q;
    logic          inv_q;
    logic          mapped;
    logic          wr_en;

    assign mapped = (cmd_addr <= PP_ADDR_W'(REG_STAT));
    assign wr_en  = cmd_valid && cmd_write && mapped;
    assign load_o = wr_en && (cmd_addr == REG_DATA);
    assign clr_o  = wr_en && (cmd_addr == REG_STAT) && cmd_wdata[0];

    // Register writes and invalid-command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            ctrl_q <= '0;
            inv_q  <= 1'b0;
        end else begin
            if (cmd_valid && !mapped)
                inv_q <= 1'b1;
            else if (wr_en && cmd_addr == REG_STAT && cmd_wdata[1])
                inv_q <= 1'b0;
            if (wr_en) begin
                case (cmd_addr)
                    REG_DATA: out_q  <= cmd_wdata;
                    REG_DIR:  dir_q  <= cmd_wdata;
                    REG_CTRL: ctrl_q <= pp_ctrl_t'(cmd_wdata[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

    // Read multiplexer; the data register mixes pins and latch per direction
    always_comb begin
        case (cmd_addr)
            REG_DATA: rdat = (pin_in & ~dir_q) | (out_q & dir_q);
            REG_DIR:  rdat = dir_q;
            REG_CTRL: rdat = DW'(ctrl_q);
            REG_STAT: rdat = DW'({inv_q, flag_i});
            default:  rdat = '0;
        endcase
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= cmd_valid && !cmd_write;
            rsp_rdata <= (cmd_valid && !cmd_write) ? rdat : '0;
        end
    end

    assign out_o  = out_q;
    assign dir_o  = dir_q;
    assign ctrl_o = ctrl_q;

    // R12: a response only follows a read command
    p_rsp_after_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && !cmd_write));
    // R11: an unmapped command leaves the direction register alone
    p_unmapped_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !mapped) |=> $stable(dir_q));
endmodule

// File: rtl/strobed_pport.sv
// Top of the strobed parallel port: register file, output strobe generator
// and input strobe interrupt detector. Assumes a single clock domain apart
// from stb_in, which is synchronised inside.
module strobed_pport
    import pport_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CLK_MHZ     = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_write,
    input  logic [PP_ADDR_W-1:0] cmd_addr,
    input  logic [DW-1:0]        cmd_wdata,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_rdata,
    input  logic [DW-1:0]        pin_in,
    output logic [DW-1:0]        pin_out,
    output logic [DW-1:0]        pin_oe,
    input  logic                 stb_in,
    output logic                 stb_out,
    output logic                 irq
);
    pp_ctrl_t ctrl;
    logic     load;
    logic     clr;
    logic     flag;

    pport_regs #(.DW(DW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .pin_in    (pin_in),
        .flag_i    (flag),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .out_o     (pin_out),
        .dir_o     (pin_oe),
        .ctrl_o    (ctrl),
        .load_o    (load),
        .clr_o     (clr)
    );

    pport_ostrobe #(.CLK_MHZ(CLK_MHZ)) ostb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .sel_i  (ctrl.width_sel),
        .stb_o  (stb_out)
    );

    pport_istrobe #(.SYNC_STAGES(SYNC_STAGES)) istb_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (stb_in),
        .lvl_i  (ctrl.lvl_mode),
        .en_i   (ctrl.irq_en),
        .clr_i  (clr),
        .flag_o (flag)
    );

    assign irq = flag;

    // R5: the strobe is high two cycles after a data write
    p_stb_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && cmd_addr == 3'd0) |=> ##1 stb_out);
    // R3: the output latch only moves on a data write
    p_pins_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_write && cmd_addr == 3'd0) |=> $stable(pin_out));
endmodule

// File: tb/strobed_pport_tb.sv
// Bench: directed stimulus, a behavioural reference model updated on each
// rising edge, and a comparison of all outputs on each falling edge.
module strobed_pport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [2:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       stb_in = 1'b0;
    logic       stb_out;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    strobed_pport dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .stb_in(stb_in), .stb_out(stb_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wcyc(input int s);
        case (s)
            0: return 4;
            1: return 8;
            2: return 20;
            default: return 40;
        endcase
    endfunction

    // Reference model state
    logic [7:0] m_out, m_dir, m_rd;
    logic [3:0] m_ctrl;
    bit m_inv, m_irq, m_pend, m_rv;
    int m_cnt;
    bit hist[$];

    always @(posedge clk) begin
        bit ev, set, clr, mapped, h1, h2;
        logic [7:0] rd;
        if (!rst_n) begin
            m_out = 0; m_dir = 0; m_ctrl = 0; m_inv = 0; m_irq = 0;
            m_pend = 0; m_cnt = 0; m_rv = 0; m_rd = 0;
            hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            mapped = (cmd_addr < 4);
            case (cmd_addr)
                3'd0: rd = (pin_in & ~m_dir) | (m_out & m_dir);
                3'd1: rd = m_dir;
                3'd2: rd = {4'b0, m_ctrl};
                3'd3: rd = {6'b0, m_inv, m_irq};
                default: rd = 0;
            endcase
            m_rv = cmd_valid && !cmd_write;
            m_rd = m_rv ? rd : 8'h00;
            h1 = hist[1]; h2 = hist[2];
            ev = m_ctrl[2] ? h1 : (h1 && !h2);
            set = ev && m_ctrl[3];
            clr = cmd_valid && cmd_write && cmd_addr == 3 && cmd_wdata[0];
            m_irq = set || (m_irq && !clr);
            if (m_pend) m_cnt = wcyc(int'(m_ctrl[1:0]));
            else if (m_cnt > 0) m_cnt--;
            m_pend = cmd_valid && cmd_write && cmd_addr == 0;
            if (cmd_valid && !mapped) m_inv = 1;
            else if (cmd_valid && cmd_write && cmd_addr == 3 && cmd_wdata[1]) m_inv = 0;
            if (cmd_valid && cmd_write && mapped) begin
                case (cmd_addr)
                    3'd0: m_out = cmd_wdata;
                    3'd1: m_dir = cmd_wdata;
                    3'd2: m_ctrl = cmd_wdata[3:0];
                    default: ;
                endcase
            end
            hist.push_front(stb_in);
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on && !done) begin
            chk("R3 pin_out vs model", pin_out, m_out);
            chk("R2 pin_oe vs model", pin_oe, m_dir);
            chk("R5 stb_out vs model", stb_out, m_cnt > 0);
            chk("R9 irq vs model", irq, m_irq);
            chk("R12 rsp_valid vs model", rsp_valid, m_rv);
            if (m_rv) chk("R12 rsp_rdata vs model", rsp_rdata, m_rd);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
        @(negedge clk);
        cmd_valid = 0; cmd_write = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        cmd_valid = 1; cmd_write = 0; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 0;
        d = rsp_rdata;
        chk("R12 rsp_valid after read", rsp_valid, 1'b1);
    endtask

    task automatic measure(output int n);
        int w = 0;
        n = 0;
        while (!stb_out && w < 10) begin @(negedge clk); w++; end
        while (stb_out && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        chk("R1 pin_out reset", pin_out, 8'h00);
        chk("R1 pin_oe reset", pin_oe, 8'h00);
        chk("R1 irq reset", irq, 1'b0);
        chk("R1 stb_out reset", stb_out, 1'b0);
        chk("R1 rsp_valid reset", rsp_valid, 1'b0);
        chk_on = 1;

        wr(1, 8'h0F);
        chk("R2 direction to pin_oe", pin_oe, 8'h0F);

        for (int s = 0; s < 4; s++) begin
            wr(2, 8'(s));
            wr(0, 8'hA0 + 8'(s));
            chk("R3 data to pin_out", pin_out, 8'hA0 + 8'(s));
            measure(n);
            chk("R5 strobe width", n, wcyc(s));
            idle(2);
        end

        wr(2, 8'h00);
        wr(0, 8'h11);
        wr(0, 8'h22);
        measure(n);
        chk("R6 restarted strobe width", n, 5);
        chk("R6 last data kept", pin_out, 8'h22);
        idle(2);

        pin_in = 8'h3C;
        wr(0, 8'hA5);
        idle(8);
        rd(0, d);
        chk("R4 mixed data read", d, 8'h35);
        rd(1, d);
        chk("R12 direction readback", d, 8'h0F);
        wr(2, 8'hFB);
        rd(2, d);
        chk("R12 control readback", d, 8'h0B);

        wr(2, 8'h08);
        stb_in = 1;
        idle(4);
        chk("R7 edge sets flag", irq, 1'b1);
        rd(3, d);
        chk("R10 status flag bit", d, 8'h01);
        wr(3, 8'h00);
        chk("R10 zero write keeps flag", irq, 1'b1);
        wr(3, 8'h01);
        chk("R10 clear flag", irq, 1'b0);
        idle(4);
        chk("R7 held strobe no re-set", irq, 1'b0);
        stb_in = 0;
        idle(4);

        wr(2, 8'h0C);
        stb_in = 1;
        idle(4);
        chk("R8 level sets flag", irq, 1'b1);
        wr(3, 8'h01);
        chk("R8 clear loses to active level", irq, 1'b1);
        stb_in = 0;
        idle(4);
        wr(3, 8'h01);
        chk("R8 clear after level gone", irq, 1'b0);

        wr(2, 8'h00);
        stb_in = 1; idle(3); stb_in = 0;
        idle(5);
        chk("R9 disabled event ignored", irq, 1'b0);
        wr(2, 8'h08);
        idle(3);
        chk("R9 no late interrupt", irq, 1'b0);

        wr(5, 8'hFF);
        rd(1, d);
        chk("R11 direction untouched", d, 8'h0F);
        chk("R11 pins untouched", pin_out, 8'hA5);
        rd(3, d);
        chk("R11 invalid flag", d, 8'h02);
        rd(6, d);
        chk("R11 unmapped read zero", d, 8'h00);
        wr(3, 8'h02);
        rd(3, d);
        chk("R10 invalid flag cleared", d, 8'h00);

        idle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule